// File: doc/BRIEF.md
# Parallel Port Forward Receiver

This block sits on the peripheral side of a host-to-peripheral parallel link running the classic compatibility handshake. The host places a byte on the 8-bit data bus and pulses its active-low strobe. The block catches the byte in a receive register and raises busy. It holds the handshake until the local CPU has fetched the byte, then answers with an active-low acknowledge pulse of programmable length and releases busy. A pending-byte flag drives an interrupt line, and a sticky overrun flag records a strobe that arrived while the block was still busy.

A small CPU register port holds four registers: control, received data, pin interface and acknowledge width. A mode field in the control register selects the forward handshake. The value 1, which is the reset value, turns on the hardware compatibility handshake. Any other value switches the hardware handshake off. Software then drives busy and acknowledge from the pin interface register and can read the live pin levels back from it. Negotiation and other transfer modes are left to firmware.

Top module: `ppf_receiver`

## Requirements
- R1: After reset the control mode field reads 1, busy is low, acknowledge is high, the interrupt is low and the acknowledge-width register (address 3) reads 4.
- R2: In mode 1, a falling edge on the strobe input, passed through two synchronising flops, captures the data bus into the receive register and raises busy and the interrupt no later than the third clock edge after the strobe falls.
- R3: A CPU read of address 1 returns the captured byte and clears the pending flag and the interrupt.
- R4: Once the pending byte has been read in mode 1, acknowledge is low for exactly N clocks, where N is the acknowledge-width register value and 0 counts as 1. Acknowledge then returns high, and busy falls one clock later.
- R5: A strobe falling edge that arrives in mode 1 while the handshake is still in progress changes neither the held byte nor the handshake, and it sets a sticky overrun flag. Writing control with bit 4 set clears that flag.
- R6: With the mode field at any value other than 1, busy follows bit 0 and acknowledge follows bit 1 of the pin interface register (address 2), and strobe edges capture nothing.
- R7: A read of address 2 returns busy in bit 0, acknowledge in bit 1 and the synchronised strobe level in bit 2. The other bits read as zero.
- R8: A read of control (address 0) returns the mode in bits 2:0, the pending flag in bit 3 and the overrun flag in bit 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| strobe_n_i | input | 1 | Host strobe, active low, asynchronous |
| data_i | input | DW | Host data bus |
| busy_o | output | 1 | Busy to host |
| ack_n_o | output | 1 | Acknowledge to host, active low |
| cpu_addr | input | 2 | Register address |
| cpu_wr | input | 1 | Register write strobe |
| cpu_rd | input | 1 | Register read strobe (read side effects) |
| cpu_wdata | input | DW | Write data |
| cpu_rdata | output | DW | Read data, combinational from the address |
| irq_o | output | 1 | Byte-pending interrupt |

## Verification
Suppose the handshake sequencer stops in a wrong state. The host sees busy stuck high, or acknowledge low while busy is low, within one clock of the faulty step. The acknowledge check counts the low time edge by edge, so an off-by-one in the width counter shows as a one-clock error in the pulse. A lost or spurious pending flag shows on the interrupt pin at the same clock edge as the capture or the read. A wrong overrun flag can be seen in the next control read.

// File: rtl/ppf_receiver.sv
module ppf_receiver #(
  parameter int DW      = 8,
  parameter int ACK_DEF = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          strobe_n_i,
  input  logic [DW-1:0] data_i,
  output logic          busy_o,
  output logic          ack_n_o,
  input  logic [1:0]    cpu_addr,
  input  logic          cpu_wr,
  input  logic          cpu_rd,
  input  logic [DW-1:0] cpu_wdata,
  output logic [DW-1:0] cpu_rdata,
  output logic          irq_o
);
  localparam logic [2:0] MODE_COMPAT = 3'd1;

  typedef enum logic [1:0] {S_IDLE, S_HOLD, S_ACK, S_REL} st_t;

  st_t           st;
  logic          s1, s2, s3;
  logic [DW-1:0] d1, d2, rx;
  logic [2:0]    mode;
  logic [DW-1:0] ack_len, cnt;
  logic          full, ovr, hw_busy, hw_ack, sw_busy, sw_ack;

  wire compat  = (mode == MODE_COMPAT);
  wire fall    = s3 & ~s2;
  wire rd_data = cpu_rd && cpu_addr == 2'd1;
  wire wr_ctrl = cpu_wr && cpu_addr == 2'd0;
  wire [DW-1:0] ack_eff = (ack_len == '0) ? DW'(1) : ack_len;

  assign busy_o  = compat ? hw_busy : sw_busy;
  assign ack_n_o = compat ? hw_ack  : sw_ack;
  assign irq_o   = full;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      {s1, s2, s3} <= 3'b111;
      d1 <= '0;
      d2 <= '0;
    end else begin
      {s1, s2, s3} <= {strobe_n_i, s1, s2};
      d1 <= data_i;
      d2 <= d1;
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      mode    <= MODE_COMPAT;
      ack_len <= DW'(ACK_DEF);
      sw_busy <= 1'b0;
      sw_ack  <= 1'b1;
    end else if (cpu_wr) begin
      case (cpu_addr)
        2'd0: mode <= cpu_wdata[2:0];
        2'd2: {sw_ack, sw_busy} <= cpu_wdata[1:0];
        2'd3: ack_len <= cpu_wdata;
        default: ;
      endcase
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st      <= S_IDLE;
      rx      <= '0;
      cnt     <= '0;
      full    <= 1'b0;
      ovr     <= 1'b0;
      hw_busy <= 1'b0;
      hw_ack  <= 1'b1;
    end else begin
      if (wr_ctrl && cpu_wdata[4]) ovr <= 1'b0;
      if (rd_data) full <= 1'b0;
      if (!compat) begin
        st      <= S_IDLE;
        hw_busy <= 1'b0;
        hw_ack  <= 1'b1;
      end else begin
        if (fall && st != S_IDLE) ovr <= 1'b1;
        case (st)
          S_IDLE: if (fall) begin
            rx      <= d2;
            full    <= 1'b1;
            hw_busy <= 1'b1;
            st      <= S_HOLD;
          end
          S_HOLD: if (rd_data) begin
            hw_ack <= 1'b0;
            cnt    <= ack_eff - DW'(1);
            st     <= S_ACK;
          end
          S_ACK: if (cnt == '0) begin
            hw_ack <= 1'b1;
            st     <= S_REL;
          end else cnt <= cnt - DW'(1);
          S_REL: begin
            hw_busy <= 1'b0;
            st      <= S_IDLE;
          end
          default: st <= S_IDLE;
        endcase
      end
    end

  always_comb begin
    cpu_rdata = '0;
    case (cpu_addr)
      2'd0: cpu_rdata[4:0] = {ovr, full, mode};
      2'd1: cpu_rdata = rx;
      2'd2: cpu_rdata[2:0] = {s2, ack_n_o, busy_o};
      default: cpu_rdata = ack_len;
    endcase
  end

  // R4
  ack_low_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compat && !ack_n_o) |-> busy_o);

  // R4
  busy_fall_ack_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compat && $past(compat) && $fell(busy_o)) |-> (ack_n_o && !full));

  // R2
  rose_full_busy_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (compat && $rose(full)) |-> busy_o);

  // R5
  overrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr && !(wr_ctrl && cpu_wdata[4])) |=> ovr);

  // R6
  sw_no_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!compat && !full) |=> !full);
endmodule

// File: tb/test_ppf_receiver.sv
module test_ppf_receiver;
  logic       clk = 1'b0, rst_n = 1'b0;
  logic       strobe_n = 1'b1;
  logic [7:0] data = '0;
  logic       busy, ack_n, irq;
  logic [1:0] addr = '0;
  logic       wr = 1'b0, rd = 1'b0;
  logic [7:0] wdata = '0, rdata;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  ppf_receiver i_ppf_receiver (
    .clk(clk), .rst_n(rst_n), .strobe_n_i(strobe_n), .data_i(data),
    .busy_o(busy), .ack_n_o(ack_n), .cpu_addr(addr), .cpu_wr(wr),
    .cpu_rd(rd), .cpu_wdata(wdata), .cpu_rdata(rdata), .irq_o(irq));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cpu_write(input logic [1:0] a, input logic [7:0] v);
    @(negedge clk); addr = a; wdata = v; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic cpu_read(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; rd = 1'b1; #1 v = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); addr = a; #1 v = rdata;
  endtask

  task automatic strobe(input logic [7:0] b);
    @(negedge clk); data = b; strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    strobe_n = 1'b1;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 40 && busy; i++) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [7:0] v;
    chk(!busy, "R1 busy", busy, 0);
    chk(ack_n, "R1 ack_n", ack_n, 1);
    chk(!irq, "R1 irq", irq, 0);
    peek(2'd0, v); chk(v == 8'h01, "R1/R8 ctrl", v, 8'h01);
    peek(2'd3, v); chk(v == 8'd4, "R1 width", v, 4);
  endtask

  task automatic t_receive(input logic [7:0] b);
    logic [7:0] v;
    @(negedge clk); data = b; strobe_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(busy, "R2 busy", busy, 1);
    chk(irq, "R2 irq", irq, 1);
    strobe_n = 1'b1;
    peek(2'd0, v); chk(v == 8'h09, "R8 ctrl pending", v, 8'h09);
    cpu_read(2'd1, v); chk(v == b, "R3 data", v, b);
    chk(!irq, "R3 irq cleared", irq, 0);
    wait_idle();
    chk(!busy && ack_n, "R4 released", {busy, ack_n}, 2'b01);
  endtask

  task automatic t_ack_width(input logic [7:0] w);
    logic [7:0] v;
    int exp_len;
    exp_len = (w == 0) ? 1 : w;
    cpu_write(2'd3, w);
    strobe(8'h3C);
    cpu_read(2'd1, v);
    for (int j = 1; j <= exp_len; j++) begin
      chk(!ack_n, "R4 ack low", ack_n, 0);
      @(negedge clk);
    end
    chk(ack_n, "R4 ack high", ack_n, 1);
    chk(busy, "R4 busy held", busy, 1);
    @(negedge clk);
    chk(!busy, "R4 busy fall", busy, 0);
  endtask

  task automatic t_overrun();
    logic [7:0] v;
    strobe(8'hA5);
    strobe(8'h5A);
    chk(busy, "R5 busy", busy, 1);
    peek(2'd0, v); chk(v == 8'h19, "R5 ctrl overrun", v, 8'h19);
    cpu_read(2'd1, v); chk(v == 8'hA5, "R5 data kept", v, 8'hA5);
    wait_idle();
    peek(2'd0, v); chk(v == 8'h11, "R5 sticky", v, 8'h11);
    cpu_write(2'd0, 8'h11);
    peek(2'd0, v); chk(v == 8'h01, "R5 clear", v, 8'h01);
  endtask

  task automatic t_software();
    logic [7:0] v;
    cpu_write(2'd0, 8'h00);
    cpu_write(2'd2, 8'h01);
    chk(busy && !ack_n, "R6 pins", {busy, ack_n}, 2'b10);
    peek(2'd2, v); chk(v == 8'h05, "R7 iface", v, 8'h05);
    @(negedge clk); data = 8'hEE; strobe_n = 1'b0;
    repeat (4) @(negedge clk);
    peek(2'd2, v); chk(v == 8'h01, "R7 strobe level", v, 8'h01);
    chk(!irq, "R6 no capture", irq, 0);
    strobe_n = 1'b1;
    peek(2'd0, v); chk(v == 8'h00, "R6 ctrl", v, 8'h00);
    cpu_write(2'd2, 8'h02);
    chk(!busy && ack_n, "R6 pins2", {busy, ack_n}, 2'b01);
    cpu_write(2'd0, 8'h01);
    chk(!busy && ack_n, "R6 back to hw", {busy, ack_n}, 2'b01);
    cpu_read(2'd1, v); chk(v != 8'hEE, "R6 data untouched", v, 0);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=1 expected=0");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_receive(8'hC3);
    t_receive(8'h00);
    t_ack_width(8'd4);
    t_ack_width(8'd1);
    t_ack_width(8'd0);
    t_ack_width(8'd7);
    t_overrun();
    t_software();
    t_receive(8'h81);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule